// File: doc/BRIEF.md
# Serial Result Readout with Shared Ready/Data Pin

This block keeps the most recent 24-bit conversion result and lets a host fetch it over one output pin that does two jobs. While no unread word is held, the pin idles high. When a result arrives and the host's chip select is at logic 1, the pin drops low to flag that data is waiting. The host then gives serial clock pulses. Each rising SCLK edge puts the next bit on the same pin, most significant bit first. The host samples each bit on the falling edge that follows.

The host's chip select and serial clock come from outside the system clock domain. Each one passes through a two-flop synchroniser, and its edges are found in the system clock domain. A result-valid pulse with its data always takes priority. If a new result lands before all 24 bits have been read, the held word is replaced without notice and the readout restarts at the new word's MSB. The FSM has four states:
- `ST_EMPTY`: nothing unread.
- `ST_READY`: a word is held and no bit has been sent.
- `ST_SHIFT`: bits 23 down to 1 are on the pin.
- `ST_LAST`: bit 0 is on the pin.

The transitions are named below:
- **load**: any state goes to `ST_READY` when a result is valid.
- **start**: `ST_READY` goes to `ST_SHIFT` on an SCLK rise with CS high.
- **step**: `ST_SHIFT` stays in `ST_SHIFT` on a rise while more than one bit remains.
- **finish**: `ST_SHIFT` goes to `ST_LAST` on the 24th rise.
- **abort**: `ST_SHIFT` goes back to `ST_READY` when CS drops.
- **retire**: `ST_LAST` goes to `ST_EMPTY` on the next SCLK edge or when CS drops.

Top module: `drdy_serial_out`

## Requirements
- R1: After reset the pin is high, and no word is held.
- R2: One clock after a result-valid pulse, with CS high, the pin is low to flag ready.
- R3: While the synchronised CS is low, the pin is high whatever word or state is held.
- R4: With CS high, the k-th rising SCLK edge (k = 1..24) puts bit 24-k of the held two's complement word on the pin, so the MSB is sent first.
- R5: After the 24th rising SCLK edge, the next SCLK falling edge returns the pin to high. The pin then stays high until the next result.
- R6: A result that arrives before all 24 bits are read replaces the held word. The pin shows ready again, and the next read delivers the new word from its MSB.
- R7: SCLK edges while no word is held leave the pin high.
- R8: CS dropping mid-read abandons the read, and the word stays held. When CS returns high, the pin shows ready, and a new read restarts at the MSB.
- R9: A CS change, launched just after one clock edge, reaches the pin after exactly two clock edges, no sooner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| res_valid | input | 1 | One-cycle pulse: a new conversion result is on res_data |
| res_data | input | DATA_W (24) | Conversion result, two's complement |
| cs_i | input | 1 | Host chip select, active high, asynchronous |
| sclk_i | input | 1 | Host serial clock, asynchronous |
| sdo_rdy_o | output | 1 | Combined ready flag (low) and serial data line |

## Verification
The bench reads back a set of 24-bit words:
- a walking one across all 24 positions, which finds swapped or stuck bit positions and shows MSB-first order;
- all-zeros, all-ones and the two sign extremes;
- a stream of pseudo-random words, which catches off-by-one errors in the bit index.

Reads cut short by a new result, or by CS falling, tell a correct restart at the MSB apart from a resumed or stale read. Clocking SCLK with no word held, and a cycle-exact probe of CS latency, cover the idle and synchroniser behaviour.

// File: rtl/drdy_pkg.sv
package drdy_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_READY = 2'd1,
        ST_SHIFT = 2'd2,
        ST_LAST  = 2'd3
    } rd_state_t;
endpackage

// File: rtl/drdy_sync.sv
module drdy_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0][W-1:0] stg_q;
    logic [W-1:0]             prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q  <= '0;
            prev_q <= '0;
        end else begin
            stg_q  <= {stg_q[STAGES-2:0], async_i};
            prev_q <= stg_q[TOP];
        end
    end

    assign sync_o = stg_q[TOP];

    for (genvar b = 0; b < W; b++) begin : g_edge
        assign rise_o[b] =  stg_q[TOP][b] & ~prev_q[b];
        assign fall_o[b] = ~stg_q[TOP][b] &  prev_q[b];
    end
endmodule

// File: rtl/drdy_shift_fsm.sv
module drdy_shift_fsm
    import drdy_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic              cs_hi,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    output logic              pin_o
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] IDX_MSB = IDX_W'(DATA_W - 1);

    rd_state_t         state_q, state_d;
    logic [DATA_W-1:0] word_q, word_d;
    logic [IDX_W-1:0]  idx_q, idx_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            word_q  <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            word_q  <= word_d;
            idx_q   <= idx_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        word_d  = word_q;
        idx_d   = idx_q;
        if (res_valid) begin                       // load
            state_d = ST_READY;
            word_d  = res_data;
            idx_d   = IDX_MSB;
        end else begin
            unique case (state_q)
                ST_EMPTY: ;
                ST_READY: if (cs_hi && sclk_rise) begin   // start
                    state_d = ST_SHIFT;
                    idx_d   = IDX_MSB;
                end
                ST_SHIFT: begin
                    if (!cs_hi) begin                     // abort
                        state_d = ST_READY;
                        idx_d   = IDX_MSB;
                    end else if (sclk_rise) begin
                        idx_d = idx_q - 1'b1;             // step
                        if (idx_q == IDX_W'(1))
                            state_d = ST_LAST;            // finish
                    end
                end
                ST_LAST: if (!cs_hi || sclk_fall || sclk_rise)
                    state_d = ST_EMPTY;                   // retire
                default: state_d = ST_EMPTY;
            endcase
        end
    end

    // outputs
    always_comb begin
        pin_o = 1'b1;
        if (cs_hi) begin
            unique case (state_q)
                ST_EMPTY: pin_o = 1'b1;
                ST_READY: pin_o = 1'b0;
                ST_SHIFT,
                ST_LAST:  pin_o = word_q[idx_q];
                default:  pin_o = 1'b1;
            endcase
        end
    end

    assert_load_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> state_q == ST_READY);
    assert_empty_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY && !res_valid) |=> state_q == ST_EMPTY);
    assert_last_lsb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LAST |-> idx_q == '0);
    assert_cs_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && !cs_hi && !res_valid) |=> state_q == ST_READY);
    assert_start_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && !res_valid && cs_hi && sclk_rise)
            |=> idx_q == IDX_MSB);
endmodule

// File: rtl/drdy_serial_out.sv
module drdy_serial_out #(
    parameter int DATA_W      = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic              cs_i,
    input  logic              sclk_i,
    output logic              sdo_rdy_o
);
    localparam int HOST_W = 2;   // bit 1: CS, bit 0: SCLK

    logic [HOST_W-1:0] host_s, host_r, host_f;

    drdy_sync #(.W(HOST_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_i, sclk_i}),
        .sync_o  (host_s),
        .rise_o  (host_r),
        .fall_o  (host_f)
    );

    drdy_shift_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_data  (res_data),
        .cs_hi     (host_s[1]),
        .sclk_rise (host_r[0]),
        .sclk_fall (host_f[0]),
        .pin_o     (sdo_rdy_o)
    );

    assert_cs_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_i && $past(!cs_i) && !host_s[1]) |-> sdo_rdy_o);
endmodule

// File: tb/sim_drdy_serial_out.sv
module sim_drdy_serial_out;
    localparam int DW   = 24;
    localparam int HALF = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          res_valid = 1'b0;
    logic [DW-1:0] res_data = '0;
    logic          cs_i = 1'b0;
    logic          sclk_i = 1'b0;
    logic          sdo_rdy_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    drdy_serial_out u0 (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .cs_i(cs_i), .sclk_i(sclk_i), .sdo_rdy_o(sdo_rdy_o)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic post(input logic [DW-1:0] d);
        @(negedge clk);
        res_valid = 1'b1;
        res_data  = d;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    // n SCLK pulses; bits collected MSB-first into the low end of w
    task automatic clock_bits(input int n, output logic [DW-1:0] w);
        w = '0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk); sclk_i = 1'b1;
            waitc(HALF);
            w = {w[DW-2:0], sdo_rdy_o};
            sclk_i = 1'b0;
            waitc(HALF);
        end
    endtask

    task automatic read_full(input string req, input logic [DW-1:0] exp);
        logic [DW-1:0] got;
        chk({req, " ready"}, {23'd0, sdo_rdy_o}, 24'd0);
        clock_bits(DW, got);
        chk(req, got, exp);
        chk("R5 idle after read", {23'd0, sdo_rdy_o}, 24'd1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] got;
        logic [31:0]   lcg;
        waitc(3);
        chk("R1 reset pin", {23'd0, sdo_rdy_o}, 24'd1);
        rst_n = 1'b1;
        cs_i  = 1'b1;
        waitc(4);
        chk("R1 after reset", {23'd0, sdo_rdy_o}, 24'd1);
        clock_bits(3, got);
        chk("R7 sclk with no word", got, 24'h000007);

        // R2: ready one clock after the pulse
        @(negedge clk); res_valid = 1'b1; res_data = 24'hA5C30F;
        @(negedge clk); res_valid = 1'b0;
        chk("R2 ready flag", {23'd0, sdo_rdy_o}, 24'd0);
        read_full("R4 first word", 24'hA5C30F);
        clock_bits(2, got);
        chk("R7 sclk after read", got, 24'h000003);

        // walking one across every bit position
        for (int b = 0; b < DW; b++) begin
            post(24'(1) << b);
            read_full("R4 walking one", 24'(1) << b);
        end
        post(24'h000000); read_full("R4 zero", 24'h000000);
        post(24'hFFFFFF); read_full("R4 minus one", 24'hFFFFFF);
        post(24'h800000); read_full("R4 most negative", 24'h800000);
        post(24'h7FFFFF); read_full("R4 most positive", 24'h7FFFFF);
        lcg = 32'h1234_5678;
        for (int i = 0; i < 16; i++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            post(lcg[31:8]);
            read_full("R4 random word", lcg[31:8]);
        end

        // R6 overwrite mid-read
        post(24'h123456);
        clock_bits(10, got);
        chk("R6 partial bits", got, 24'h123456 >> 14);
        post(24'hFEDCBA);
        read_full("R6 new word from MSB", 24'hFEDCBA);

        // R8 and R3: CS dropped mid-read
        post(24'h3C3C3C);
        clock_bits(5, got);
        @(negedge clk); cs_i = 1'b0;
        waitc(4);
        chk("R3 pin high with CS low", {23'd0, sdo_rdy_o}, 24'd1);
        clock_bits(3, got);
        chk("R3 sclk with CS low", got, 24'h000007);
        @(negedge clk); cs_i = 1'b1;
        waitc(4);
        read_full("R8 restart at MSB", 24'h3C3C3C);

        // R3: result arrives while CS low; R9 latency
        @(negedge clk); cs_i = 1'b0;
        waitc(4);
        post(24'h0F0F0F);
        waitc(2);
        chk("R3 held word hidden", {23'd0, sdo_rdy_o}, 24'd1);
        @(negedge clk); cs_i = 1'b1;
        @(negedge clk);
        chk("R9 one edge no change", {23'd0, sdo_rdy_o}, 24'd1);
        @(negedge clk);
        chk("R9 two edges ready", {23'd0, sdo_rdy_o}, 24'd0);
        read_full("R4 read after CS return", 24'h0F0F0F);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule